// File: doc/BRIEF.md
# Video Memory Access Slot Arbiter

This block sits between a processor data port and three video memories: a byte-wide video RAM, a 64-word color RAM and a 40-word vertical-scroll RAM. Port writes are not applied at once. Each write is placed in a four-entry queue together with a time stamp, and it is retired only in the external access slots that a timing generator signals with a one-cycle strobe. Port reads use the same slots. A pending read takes the next slot ahead of any queued write. The reader is held busy until its data is ready.

A 16-bit video RAM word is moved as two bytes, one per slot: the high byte at the given address and the low byte at the address with bit 0 inverted. The color and scroll RAMs keep only part of each word as real storage. When they are read, the bits that have no storage return the matching bits of the last value that the queue wrote into any memory. The command code and the address are held by the register logic outside this block and apply to both port directions.

Top module: `vmem_slot_arbiter`

## Requirements
- R1: After reset, wr_stall, rd_busy and rd_valid are 0, rd_data is 0, the queue is empty and the last-written value is 0.
- R2: The queue holds 4 entries. With 4 entries queued, wr_stall is 1, and a write presented while wr_stall is 1 is dropped and never reaches memory.
- R3: An accepted write is stamped with cycle_cnt + 2 (as cycle_cnt is sampled at acceptance). The head entry is retired in a slot only if its stamp is less than or equal to cycle_cnt. Otherwise that slot writes nothing.
- R4: While a read is pending, the next slot serves the read and retires no queued write. A read finishes only in a slot, and rd_valid rises for one cycle after that slot.
- R5: A video RAM write takes two slots. The first writes value[15:8] at address, and the entry stays queued. The second writes value[7:0] at address XOR 1 and removes the entry.
- R6: A video RAM read takes two slots and returns {byte[address], byte[address XOR 1]}.
- R7: A color RAM read returns (word & 0x0EEE) | (last & 0xF111). The word index is address[6:1].
- R8: A scroll RAM access uses word index address[6:1]. A read below index 40 returns (word & 0x03FF) | (last & 0xFC00). A read at index 40 or above returns 0. A write at index 40 or above is discarded.
- R9: The last-written value is loaded with the full 16-bit entry value by every color RAM write, every in-range scroll RAM write and every video RAM low-byte write. It is not loaded by a video RAM high-byte write or by a discarded scroll write.
- R10: A read whose code is not one of the three read codes returns 0 after exactly one slot.
- R11: cmd_code values: 4'h0 video RAM read, 4'h1 video RAM write, 4'h3 color RAM write, 4'h4 scroll RAM read, 4'h5 scroll RAM write, 4'h8 color RAM read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_cnt | input | 16 | Current cycle count from the timing generator |
| slot_stb | input | 1 | One-cycle strobe marking an external access slot |
| cmd_code | input | 4 | Latched command code; selects memory and direction |
| cmd_addr | input | 16 | Latched access address |
| wr_req | input | 1 | Data-port write request |
| wr_data | input | 16 | Data-port write value |
| rd_req | input | 1 | Data-port read request |
| wr_stall | output | 1 | Write not accepted: queue full or read pending |
| rd_busy | output | 1 | A read is pending |
| rd_valid | output | 1 | One-cycle pulse when rd_data holds a finished read |
| rd_data | output | 16 | Read result |

## Verification
The bench drives writes one at a time with slots between them, bursts that fill the queue with no slots, and reads issued while the queue is full or while a video RAM entry is half-written. Odd and even video RAM addresses separate correct byte placement from swapped bytes. Reads of the color and scroll RAMs are placed after writes with distinct high bits, which shows which write last loaded the fill value, and in particular that discarded or high-byte-only writes did not load it. Freezing the cycle count shows the difference between slots that are held back by the stamp and slots that retire an entry. The bench also counts the slots each read takes.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  localparam int VM_ADDR_W  = 16;
  localparam int VM_DATA_W  = 16;
  localparam int VM_STAMP_W = 16;

  localparam logic [3:0] OP_VRAM_RD  = 4'h0;
  localparam logic [3:0] OP_VRAM_WR  = 4'h1;
  localparam logic [3:0] OP_CRAM_WR  = 4'h3;
  localparam logic [3:0] OP_VSRAM_RD = 4'h4;
  localparam logic [3:0] OP_VSRAM_WR = 4'h5;
  localparam logic [3:0] OP_CRAM_RD  = 4'h8;

  localparam logic [VM_DATA_W-1:0] CRAM_KEEP  = 16'h0EEE;
  localparam logic [VM_DATA_W-1:0] VSRAM_KEEP = 16'h03FF;

  typedef struct packed {
    logic [3:0]            code;
    logic [VM_ADDR_W-1:0]  addr;
    logic [VM_DATA_W-1:0]  value;
    logic [VM_STAMP_W-1:0] stamp;
    logic                  partial;
  } vm_entry_t;
endpackage

// File: rtl/vmem_ram.sv
module vmem_ram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vmem_wr_fifo.sv
module vmem_wr_fifo
  import vmem_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  vm_entry_t        push_entry,
  input  logic             pop,
  input  logic             set_partial,
  output vm_entry_t        head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  vm_entry_t        ent_q [DEPTH];
  vm_entry_t        ent_d [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ent_d = ent_q;
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (push) begin
      ent_d[wp_q] = push_entry;
      wp_d        = wp_q + PTR_W'(1);
    end
    if (set_partial) ent_d[rp_q].partial = 1'b1;
    if (pop) rp_d = rp_q + PTR_W'(1);
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (push || set_partial) ent_q <= ent_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  assign head  = ent_q[rp_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/vmem_slot_arbiter.sv
module vmem_slot_arbiter
  import vmem_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int VRAM_BYTES  = 256,
  parameter int CRAM_WORDS  = 64,
  parameter int VSRAM_WORDS = 40,
  parameter int WR_DELAY    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [VM_STAMP_W-1:0] cycle_cnt,
  input  logic                  slot_stb,
  input  logic [3:0]            cmd_code,
  input  logic [VM_ADDR_W-1:0]  cmd_addr,
  input  logic                  wr_req,
  input  logic [VM_DATA_W-1:0]  wr_data,
  input  logic                  rd_req,
  output logic                  wr_stall,
  output logic                  rd_busy,
  output logic                  rd_valid,
  output logic [VM_DATA_W-1:0]  rd_data
);
  localparam int VRAM_AW    = $clog2(VRAM_BYTES);
  localparam int CRAM_AW    = $clog2(CRAM_WORDS);
  localparam int VSRAM_AW   = $clog2(VSRAM_WORDS);
  localparam int WIDX_W     = 6;
  localparam int FIFO_CNT_W = $clog2(FIFO_DEPTH) + 1;
  localparam logic [WIDX_W:0] VS_LIMIT = (WIDX_W+1)'(VSRAM_WORDS);

  // queue
  vm_entry_t             fifo_head, push_entry;
  logic [FIFO_CNT_W-1:0] fifo_count;
  logic                  fifo_full, fifo_empty, fifo_pop, fifo_mark;
  logic                  wr_take, rd_take, rd_slot, wr_slot;

  // memories
  logic                  vram_we, cram_we, vsram_we;
  logic [VRAM_AW-1:0]    vram_waddr, vram_raddr;
  logic [7:0]            vram_wdata, vram_rdata;
  logic [VM_DATA_W-1:0]  cram_rdata, vsram_rdata;
  logic [WIDX_W-1:0]     head_idx, rd_idx;
  logic                  head_vs_ok, rd_vs_ok;

  // state
  logic                  rd_active_q, rd_active_d, rd_phase_q, rd_phase_d;
  logic [3:0]            rd_code_q, rd_code_d;
  logic [VM_ADDR_W-1:0]  rd_addr_q, rd_addr_d;
  logic [7:0]            rd_hi_q, rd_hi_d;
  logic                  rd_valid_q, rd_valid_d;
  logic [VM_DATA_W-1:0]  rd_data_q, rd_data_d, last_q, last_d;
  logic                  rd_done;
  logic [VM_DATA_W-1:0]  rd_result;

  assign wr_take = wr_req && !wr_stall;
  assign rd_take = rd_req && !rd_active_q && !wr_req;
  assign rd_slot = slot_stb && rd_active_q;
  assign wr_slot = slot_stb && !rd_active_q && !fifo_empty
                   && (fifo_head.stamp <= cycle_cnt);

  always_comb begin
    push_entry         = '0;
    push_entry.code    = cmd_code;
    push_entry.addr    = cmd_addr;
    push_entry.value   = wr_data;
    push_entry.stamp   = cycle_cnt + VM_STAMP_W'(WR_DELAY);
    push_entry.partial = 1'b0;
  end

  vmem_wr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_take), .push_entry(push_entry),
    .pop(fifo_pop), .set_partial(fifo_mark), .head(fifo_head),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  // write side: head entry decode
  assign head_idx   = fifo_head.addr[WIDX_W:1];
  assign head_vs_ok = ({1'b0, head_idx} < VS_LIMIT);
  assign vram_we    = wr_slot && (fifo_head.code == OP_VRAM_WR);
  assign cram_we    = wr_slot && (fifo_head.code == OP_CRAM_WR);
  assign vsram_we   = wr_slot && (fifo_head.code == OP_VSRAM_WR) && head_vs_ok;
  assign fifo_mark  = vram_we && !fifo_head.partial;
  assign fifo_pop   = wr_slot && !fifo_mark;
  assign vram_waddr = fifo_head.partial ? (fifo_head.addr[VRAM_AW-1:0] ^ VRAM_AW'(1))
                                        : fifo_head.addr[VRAM_AW-1:0];
  assign vram_wdata = fifo_head.partial ? fifo_head.value[7:0] : fifo_head.value[15:8];

  always_comb begin
    last_d = last_q;
    if ((vram_we && fifo_head.partial) || cram_we || vsram_we) last_d = fifo_head.value;
  end

  // read side
  assign rd_idx     = rd_addr_q[WIDX_W:1];
  assign rd_vs_ok   = ({1'b0, rd_idx} < VS_LIMIT);
  assign vram_raddr = rd_phase_q ? (rd_addr_q[VRAM_AW-1:0] ^ VRAM_AW'(1))
                                 : rd_addr_q[VRAM_AW-1:0];

  vmem_ram #(.WIDTH(8), .DEPTH(VRAM_BYTES)) u_vram (
    .clk(clk), .we(vram_we), .waddr(vram_waddr), .wdata(vram_wdata),
    .raddr(vram_raddr), .rdata(vram_rdata)
  );
  vmem_ram #(.WIDTH(VM_DATA_W), .DEPTH(CRAM_WORDS)) u_cram (
    .clk(clk), .we(cram_we), .waddr(head_idx[CRAM_AW-1:0]), .wdata(fifo_head.value),
    .raddr(rd_idx[CRAM_AW-1:0]), .rdata(cram_rdata)
  );
  vmem_ram #(.WIDTH(VM_DATA_W), .DEPTH(VSRAM_WORDS)) u_vsram (
    .clk(clk), .we(vsram_we), .waddr(head_idx[VSRAM_AW-1:0]), .wdata(fifo_head.value),
    .raddr(rd_idx[VSRAM_AW-1:0]), .rdata(vsram_rdata)
  );

  always_comb begin
    rd_done   = 1'b0;
    rd_result = '0;
    rd_hi_d   = rd_hi_q;
    rd_phase_d = rd_phase_q;
    if (rd_slot) begin
      case (rd_code_q)
        OP_VRAM_RD: begin
          if (!rd_phase_q) begin
            rd_hi_d    = vram_rdata;
            rd_phase_d = 1'b1;
          end else begin
            rd_done   = 1'b1;
            rd_result = {rd_hi_q, vram_rdata};
          end
        end
        OP_CRAM_RD: begin
          rd_done   = 1'b1;
          rd_result = (cram_rdata & CRAM_KEEP) | (last_q & ~CRAM_KEEP);
        end
        OP_VSRAM_RD: begin
          rd_done   = 1'b1;
          rd_result = rd_vs_ok ? ((vsram_rdata & VSRAM_KEEP) | (last_q & ~VSRAM_KEEP)) : '0;
        end
        default: rd_done = 1'b1;
      endcase
    end
    rd_code_d   = rd_take ? cmd_code : rd_code_q;
    rd_addr_d   = rd_take ? cmd_addr : rd_addr_q;
    if (rd_take) rd_phase_d = 1'b0;
    rd_active_d = rd_take ? 1'b1 : (rd_done ? 1'b0 : rd_active_q);
    rd_valid_d  = rd_done;
    rd_data_d   = rd_done ? rd_result : rd_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active_q <= 1'b0;
      rd_phase_q  <= 1'b0;
      rd_code_q   <= '0;
      rd_addr_q   <= '0;
      rd_hi_q     <= '0;
      rd_valid_q  <= 1'b0;
      rd_data_q   <= '0;
      last_q      <= '0;
    end else begin
      rd_active_q <= rd_active_d;
      rd_phase_q  <= rd_phase_d;
      rd_code_q   <= rd_code_d;
      rd_addr_q   <= rd_addr_d;
      rd_hi_q     <= rd_hi_d;
      rd_valid_q  <= rd_valid_d;
      rd_data_q   <= rd_data_d;
      last_q      <= last_d;
    end
  end

  assign wr_stall = fifo_full || rd_active_q;
  assign rd_busy  = rd_active_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/vmem_slot_arbiter_chk.sv
module vmem_slot_arbiter_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_stb,
  input logic             rd_busy,
  input logic             wr_stall,
  input logic             rd_valid,
  input logic [15:0]      rd_data,
  input logic [3:0]       rd_code,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic [15:0]      head_stamp,
  input logic [15:0]      cycle_cnt
);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  assert_full_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CNT_W'(DEPTH)) |-> wr_stall);

  assert_future_stamp_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && !rd_busy && fifo_cnt != '0 && head_stamp > cycle_cnt)
      |=> (fifo_cnt >= $past(fifo_cnt)));

  assert_read_keeps_fifo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && rd_busy) |=> (fifo_cnt == $past(fifo_cnt)));

  assert_done_in_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(slot_stb) && $past(rd_busy)));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_undecoded_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_code != 4'h0 && rd_code != 4'h4 && rd_code != 4'h8) |-> (rd_data == 16'h0));
endmodule

bind vmem_slot_arbiter vmem_slot_arbiter_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(FIFO_CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .rd_busy(rd_busy), .wr_stall(wr_stall),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_code(rd_code_q), .fifo_cnt(fifo_count),
  .head_stamp(fifo_head.stamp), .cycle_cnt(cycle_cnt)
);

// File: tb/vmem_slot_arbiter_bench.sv
module vmem_slot_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cyc;
  logic        cyc_run;
  logic        slot_stb, wr_req, rd_req;
  logic [3:0]  cmd_code;
  logic [15:0] cmd_addr, wr_data;
  logic        wr_stall, rd_busy, rd_valid;
  logic [15:0] rd_data;

  int n_vec = 0;
  int n_err = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 16'd0;
    else if (cyc_run) cyc <= cyc + 16'd1;
  end

  vmem_slot_arbiter u_vmem_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .cycle_cnt(cyc), .slot_stb(slot_stb),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .wr_req(wr_req), .wr_data(wr_data),
    .rd_req(rd_req), .wr_stall(wr_stall), .rd_busy(rd_busy), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_err++;
        $display("FAIL R4 unexpected rd_valid: actual %h expected none", rd_data);
      end else begin
        check(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic slots(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slot_stb = 1'b1;
      @(negedge clk) slot_stb = 1'b0;
    end
  endtask

  task automatic wr(input logic [3:0] code, input logic [15:0] addr, input logic [15:0] data);
    @(negedge clk);
    while (wr_stall) @(negedge clk);
    cmd_code = code; cmd_addr = addr; wr_data = data; wr_req = 1'b1;
    @(negedge clk) wr_req = 1'b0;
  endtask

  task automatic wr_force(input logic [3:0] code, input logic [15:0] addr, input logic [15:0] data);
    @(negedge clk);
    cmd_code = code; cmd_addr = addr; wr_data = data; wr_req = 1'b1;
    @(negedge clk) wr_req = 1'b0;
  endtask

  task automatic rd(input logic [3:0] code, input logic [15:0] addr, input logic [15:0] exp,
                    input int nslots, input string tag);
    int n;
    @(negedge clk);
    cmd_code = code; cmd_addr = addr; rd_req = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk) rd_req = 1'b0;
    n = 0;
    while (rd_busy && n < 8) begin
      slot_stb = 1'b1;
      @(negedge clk) slot_stb = 1'b0;
      n++;
      @(negedge clk);
    end
    check(16'(n), 16'(nslots), {tag, " slot count"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_run = 1'b1; slot_stb = 1'b0; wr_req = 1'b0; rd_req = 1'b0;
    cmd_code = 4'h0; cmd_addr = 16'h0; wr_data = 16'h0;
    repeat (3) @(negedge clk);
    check(16'(wr_stall), 16'd0, "R1 wr_stall");
    check(16'(rd_busy), 16'd0, "R1 rd_busy");
    check(16'(rd_valid), 16'd0, "R1 rd_valid");
    check(rd_data, 16'h0, "R1 rd_data");
    rst_n = 1'b1;
    @(negedge clk);
    check(16'(wr_stall), 16'd0, "R1 wr_stall after release");

    // preset cells used later
    wr(4'h3, 16'h001C, 16'h0000);
    wr(4'h3, 16'h0028, 16'h0000);
    wr(4'h1, 16'h0030, 16'h0000);
    slots(8);

    // R7 R9 R11 color RAM fill from last value
    wr(4'h3, 16'h0004, 16'hABCD);
    wr(4'h3, 16'h0006, 16'h1111);
    slots(6);
    rd(4'h8, 16'h0004, 16'h1BDD, 1, "R7 cram mask/fill");

    // R8 scroll RAM
    wr(4'h5, 16'h000A, 16'h8765);
    wr(4'h3, 16'h0006, 16'h4242);
    slots(6);
    rd(4'h4, 16'h000A, 16'h4365, 1, "R8 vsram mask/fill");
    wr(4'h5, 16'h0050, 16'h9999);
    slots(4);
    rd(4'h4, 16'h0050, 16'h0000, 1, "R8 vsram index 40 reads 0");
    rd(4'h8, 16'h0004, 16'h4ACC, 1, "R9 discarded vsram write keeps last");

    // R5 R6 byte split and order
    wr(4'h1, 16'h0021, 16'h1234);
    slots(6);
    rd(4'h0, 16'h0021, 16'h1234, 2, "R6 vram read odd addr");
    rd(4'h0, 16'h0020, 16'h3412, 2, "R5 vram low byte at addr^1");
    rd(4'h8, 16'h0004, 16'h1ADC, 1, "R9 vram low write loads last");

    // R5 partial entry
    wr(4'h1, 16'h0030, 16'hBEEF);
    slots(1);
    rd(4'h8, 16'h0004, 16'h1ADC, 1, "R9 high-byte write keeps last");
    rd(4'h0, 16'h0030, 16'hBE00, 2, "R5 after first slot only high byte");
    slots(2);
    rd(4'h0, 16'h0030, 16'hBEEF, 2, "R5 after second slot");
    rd(4'h8, 16'h0004, 16'hBACD, 1, "R9 last after vram word");

    // R2 R4 full queue, read stealing
    wr(4'h3, 16'h0014, 16'h1000);
    wr(4'h3, 16'h0016, 16'h2000);
    wr(4'h3, 16'h0018, 16'h3000);
    wr(4'h3, 16'h001A, 16'h4001);
    @(negedge clk);
    check(16'(wr_stall), 16'd1, "R2 stall when 4 queued");
    wr_force(4'h3, 16'h001C, 16'h7777);
    rd(4'h8, 16'h0004, 16'hBACD, 1, "R4 read ahead of queued writes");
    check(16'(wr_stall), 16'd1, "R4 read slot retired no write");
    slots(8);
    check(16'(wr_stall), 16'd0, "R2 drained");
    rd(4'h8, 16'h001C, 16'h4001, 1, "R2 write while full dropped");

    // R3 stamp gating
    @(negedge clk) cyc_run = 1'b0;
    wr(4'h3, 16'h0028, 16'h0E0E);
    slots(4);
    rd(4'h8, 16'h0028, 16'h4001, 1, "R3 future stamp not retired");
    @(negedge clk) cyc_run = 1'b1;
    slots(4);
    rd(4'h8, 16'h0028, 16'h0E0E, 1, "R3 retired once stamp reached");

    // R10 undecoded reads
    rd(4'hF, 16'h0004, 16'h0000, 1, "R10 code F");
    rd(4'h1, 16'h0004, 16'h0000, 1, "R10 write code as read");

    repeat (4) @(negedge clk);
    check(16'(exp_q.size()), 16'd0, "R4 all reads completed");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule